// File: doc/BRIEF.md
# Serial Frame-Start and Byte-Delimiter Generator

This block watches a serial receive stream, one bit per rising edge of `clk_i` while `rx_en_i` is high. It hunts for the start-of-frame delimiter that follows an alternating 1/0 preamble. Once the delimiter is found, it enters a frame state. In that state it repeats every received bit on a registered serial output, next to a byte-delimiting strobe. Each rising edge of the strobe falls on the first bit of a byte, and the first such edge falls on the first destination-address byte.

An address checker outside the block can use the strobe and the serial output to frame bytes without counting bits itself. The block also takes two reject sources: an active-low external reject pin and an active-high reject from an internal address filter. It samples both on the edge that takes the last destination-address bit. From that sample it gives one accept or reject pulse per frame. Dropping `rx_en_i` ends or aborts a frame and sends the block back to hunting.

Top module: `sfd_byte_strobe`

## Requirements
- R1: Bits are taken only on rising edges of `clk_i` with `rx_en_i` high. A low `rx_en_i` clears the hunt, so a preamble broken by a disabled cycle does not count, and data presented while disabled never starts a frame.
- R2: The delimiter is the eight bits 1,0,1,0,1,0,1,1, oldest first. It is accepted only when at least `MIN_PRE_BITS` (default 4) earlier bits continue the 1/0 alternation into it. `frame_active_o` rises in the cycle after the edge that samples the closing 1.
- R3: A delimiter preceded by fewer than `MIN_PRE_BITS` alternating bits (for example 2) is not accepted, and `frame_active_o` stays low.
- R4: While a frame is active, after each edge `ser_data_o` equals the bit that edge sampled. The first such bit is the first destination-address bit.
- R5: Number the in-frame bits k = 0, 1, ... starting at the first destination-address bit. Alongside bit k, `strobe_o` is high when k mod 8 is 0 to 3 and low when it is 4 to 7. It therefore rises with the first bit of every byte.
- R6: `strobe_o` and `ser_data_o` are low whenever `frame_active_o` is low.
- R7: On the edge that samples bit 8*`DA_BYTES`-1 (bit 47 by default), the block evaluates `int_reject_i | ~ext_reject_ni`. In the next cycle it pulses `frame_reject_o` if that value is 1, or `frame_accept_o` if it is 0, for one cycle. There is exactly one pulse per completed address, and the values on other cycles have no effect.
- R8: If `rx_en_i` is low in a frame, `frame_active_o`, `strobe_o` and `ser_data_o` are low in the next cycle. A frame aborted before its last address bit gives no pulse, and a later frame is handled normally.
- R9: While `rst_ni` is low, every output is low and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive data valid |
| rx_data_i | input | 1 | Serial receive data |
| int_reject_i | input | 1 | Internal address filter reject, active high |
| ext_reject_ni | input | 1 | External reject, active low |
| frame_active_o | output | 1 | A frame is being received after its delimiter |
| strobe_o | output | 1 | Byte delimiter strobe, rising on the first bit of each byte |
| ser_data_o | output | 1 | Registered post-delimiter serial data |
| frame_reject_o | output | 1 | One-cycle reject verdict |
| frame_accept_o | output | 1 | One-cycle accept verdict |

## Verification
The hardest cases to reach are the boundaries of delimiter acceptance. In one, a preamble exactly `MIN_PRE_BITS` long is accepted while one two bits shorter is not. In the other, a run of alternation is broken by a single disabled cycle just before the delimiter. The stimulus builds these from explicit bit lists, varying only the preamble length or inserting the gap. To show that the reject sources are sampled only on the last address bit, the bench drives them to the opposite verdict on every other bit of the frame. An abort after 20 address bits, followed by a full frame, shows that the counters restart cleanly.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_FRAME = 1'b1} rx_state_e;
  localparam int unsigned SFD_W = 8;
  // oldest bit in the MSB
  localparam logic [SFD_W-1:0] SFD_PATTERN = 8'b1010_1011;
endpackage

// File: rtl/sfd_detect.sv
`timescale 1ns/1ps
module sfd_detect
  import sfd_pkg::*;
#(
  parameter int unsigned MIN_PRE_BITS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic hit_o
);
  // alternating bits needed: preamble plus the 7 alternating delimiter bits
  localparam int unsigned RUN_MAX = (SFD_W - 1) + MIN_PRE_BITS;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  logic [SFD_W-2:0] hist_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_d;

  always_comb begin
    if (run_q == '0)               run_d = RUN_W'(1);
    else if (bit_i != hist_q[0])   run_d = (run_q == RUN_W'(RUN_MAX)) ? run_q : run_q + RUN_W'(1);
    else                           run_d = RUN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      run_q  <= '0;
    end else if (clear_i) begin
      hist_q <= '0;
      run_q  <= '0;
    end else if (valid_i) begin
      hist_q <= {hist_q[SFD_W-3:0], bit_i};
      run_q  <= run_d;
    end
  end

  assign hit_o = valid_i && !clear_i
              && ({hist_q, bit_i} == SFD_PATTERN)
              && (run_q >= RUN_W'(RUN_MAX));
endmodule

// File: rtl/byte_strobe_gen.sv
`timescale 1ns/1ps
module byte_strobe_gen #(
  parameter int unsigned DA_BYTES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic strobe_o,
  output logic ser_o,
  output logic da_done_o
);
  localparam int unsigned BYTE_W = $clog2(DA_BYTES + 1);

  logic [2:0]        bit_cnt_q;
  logic [BYTE_W-1:0] byte_cnt_q;
  logic              strobe_q;
  logic              ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      strobe_q   <= 1'b0;
      ser_q      <= 1'b0;
    end else if (clear_i) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      strobe_q   <= 1'b0;
      ser_q      <= 1'b0;
    end else if (adv_i) begin
      ser_q     <= bit_i;
      strobe_q  <= ~bit_cnt_q[2];   // high for counts 0..3
      bit_cnt_q <= bit_cnt_q + 3'd1;
      if (bit_cnt_q == 3'd7 && byte_cnt_q != BYTE_W'(DA_BYTES))
        byte_cnt_q <= byte_cnt_q + BYTE_W'(1);
    end
  end

  assign strobe_o  = strobe_q;
  assign ser_o     = ser_q;
  assign da_done_o = adv_i && !clear_i && (bit_cnt_q == 3'd7)
                  && (byte_cnt_q == BYTE_W'(DA_BYTES - 1));

  // R5
  strobe_moves_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(strobe_q) |-> $past(adv_i || clear_i));
endmodule

// File: rtl/reject_combine.sv
`timescale 1ns/1ps
module reject_combine (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic int_reject_i,
  input  logic ext_reject_ni,
  output logic reject_o,
  output logic accept_o
);
  logic reject_q, accept_q;
  logic any_reject;

  assign any_reject = int_reject_i | ~ext_reject_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reject_q <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      reject_q <= decide_i &  any_reject;
      accept_q <= decide_i & ~any_reject;
    end
  end

  assign reject_o = reject_q;
  assign accept_o = accept_q;

  // R7
  reject_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_q |-> $past(int_reject_i || !ext_reject_ni));
  // R7
  accept_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_q |-> $past(!int_reject_i && ext_reject_ni));
endmodule

// File: rtl/sfd_byte_strobe.sv
`timescale 1ns/1ps
module sfd_byte_strobe
  import sfd_pkg::*;
#(
  parameter int unsigned MIN_PRE_BITS = 4,
  parameter int unsigned DA_BYTES     = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic rx_data_i,
  input  logic int_reject_i,
  input  logic ext_reject_ni,
  output logic frame_active_o,
  output logic strobe_o,
  output logic ser_data_o,
  output logic frame_reject_o,
  output logic frame_accept_o
);
  rx_state_e state_q, state_d;
  logic sfd_hit, in_frame, gen_clear, gen_adv, da_done;

  assign in_frame  = (state_q == ST_FRAME);
  assign gen_adv   = in_frame && rx_en_i;
  assign gen_clear = !in_frame || !rx_en_i;

  sfd_detect #(.MIN_PRE_BITS(MIN_PRE_BITS)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!rx_en_i),
    .valid_i (rx_en_i && !in_frame),
    .bit_i   (rx_data_i),
    .hit_o   (sfd_hit)
  );

  byte_strobe_gen #(.DA_BYTES(DA_BYTES)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (gen_clear),
    .adv_i     (gen_adv),
    .bit_i     (rx_data_i),
    .strobe_o  (strobe_o),
    .ser_o     (ser_data_o),
    .da_done_o (da_done)
  );

  reject_combine u_reject (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .decide_i      (da_done),
    .int_reject_i  (int_reject_i),
    .ext_reject_ni (ext_reject_ni),
    .reject_o      (frame_reject_o),
    .accept_o      (frame_accept_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT:  if (sfd_hit)  state_d = ST_FRAME;
      ST_FRAME: if (!rx_en_i) state_d = ST_HUNT;
      default:                state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HUNT;
    else         state_q <= state_d;
  end

  assign frame_active_o = in_frame;

  // R6
  idle_outputs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_active_o |-> (!strobe_o && !ser_data_o));
  // R2
  entry_on_closing_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_active_o) |-> $past(rx_en_i && rx_data_i));
  // R8
  abort_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_active_o && !rx_en_i) |=> !frame_active_o);
  // R7
  verdict_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_reject_o && frame_accept_o));
  // R7
  verdict_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_reject_o || frame_accept_o) |=> !(frame_reject_o || frame_accept_o));
endmodule

// File: tb/sfd_byte_strobe_tb.sv
`timescale 1ns/1ps
module sfd_byte_strobe_tb;
  localparam int MIN_PRE = 4;
  localparam int DA_BITS = 48;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en = 1'b0, rx_data = 1'b0, int_rej = 1'b0, ext_rej_n = 1'b1;
  logic active, strobe, ser, rej, acc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sfd_byte_strobe #(.MIN_PRE_BITS(MIN_PRE), .DA_BYTES(6)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en), .rx_data_i(rx_data),
    .int_reject_i(int_rej), .ext_reject_ni(ext_rej_n),
    .frame_active_o(active), .strobe_o(strobe), .ser_data_o(ser),
    .frame_reject_o(rej), .frame_accept_o(acc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, sample 1 ns after the following rising edge
  task automatic send_bit(input logic en, input logic b);
    @(negedge clk);
    rx_en = en;
    rx_data = b;
    @(posedge clk);
    #1;
  endtask

  task automatic send_preamble_sfd(input int pre_len);
    for (int i = 0; i < pre_len; i++) send_bit(1'b1, (i % 2) == 0);
    for (int i = 7; i >= 0; i--) send_bit(1'b1, (8'hAB >> i) & 1);
  endtask

  function automatic logic da_bit(input int k);
    return logic'(((k * 7 + 3) >> 2) & 1);
  endfunction

  task automatic t_reset;
    chk("R9 frame_active", active, 0);
    chk("R9 strobe", strobe, 0);
    chk("R9 ser_data", ser, 0);
    chk("R9 verdicts", {rej, acc}, 0);
  endtask

  task automatic t_frame(input int pre_len, input logic ir, input logic en_n);
    logic exp_rej;
    exp_rej = ir | ~en_n;
    send_preamble_sfd(pre_len);
    chk("R2 frame_active after delimiter", active, 1);
    chk("R6 strobe before address", strobe, 0);
    for (int k = 0; k < DA_BITS; k++) begin
      // opposite verdict on every bit except the decision bit
      int_rej   = (k == DA_BITS - 1) ? ir   : ~ir;
      ext_rej_n = (k == DA_BITS - 1) ? en_n : ~en_n;
      send_bit(1'b1, da_bit(k));
      chk("R4 ser_data", ser, da_bit(k));
      chk("R5 strobe phase", strobe, (k % 8) < 4);
      if (k == DA_BITS - 1) chk("R7 verdict", {rej, acc}, {exp_rej, ~exp_rej});
      else                  chk("R7 no early verdict", {rej, acc}, 0);
    end
    int_rej = ~ir; ext_rej_n = ~en_n;
    send_bit(1'b1, 1'b0);
    chk("R7 single pulse", {rej, acc}, 0);
    chk("R5 strobe rises on next byte", strobe, 1);
    send_bit(1'b0, 1'b0);
    chk("R8 frame end", active, 0);
    chk("R6 strobe idle", strobe, 0);
    chk("R6 ser idle", ser, 0);
  endtask

  task automatic t_short_preamble;
    send_preamble_sfd(MIN_PRE - 2);
    chk("R3 short preamble rejected", active, 0);
    send_bit(1'b1, 1'b0);
    chk("R3 still hunting", active, 0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic t_disabled_data;
    for (int i = 0; i < 12; i++) send_bit(1'b0, (i % 2) == 0);
    for (int i = 7; i >= 0; i--) send_bit(1'b0, (8'hAB >> i) & 1);
    chk("R1 disabled data ignored", active, 0);
    chk("R1 ser idle", ser, 0);
  endtask

  task automatic t_gap_in_preamble;
    for (int i = 0; i < MIN_PRE; i++) send_bit(1'b1, (i % 2) == 0);
    send_bit(1'b0, 1'b0);
    for (int i = 7; i >= 0; i--) send_bit(1'b1, (8'hAB >> i) & 1);
    chk("R1 gap restarts hunt", active, 0);
    send_bit(1'b0, 1'b0);
  endtask

  task automatic t_abort;
    int_rej = 1'b0; ext_rej_n = 1'b1;
    send_preamble_sfd(MIN_PRE + 2);
    chk("R2 long preamble accepted", active, 1);
    for (int k = 0; k < 20; k++) send_bit(1'b1, da_bit(k));
    chk("R5 strobe mid-frame", strobe, (19 % 8) < 4);
    send_bit(1'b0, 1'b1);
    chk("R8 abort active", active, 0);
    chk("R8 abort strobe", strobe, 0);
    chk("R8 abort ser", ser, 0);
    for (int i = 0; i < 40; i++) begin
      send_bit(1'b0, 1'b0);
      chk("R8 no verdict after abort", {rej, acc}, 0);
    end
    t_frame(MIN_PRE, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    send_bit(1'b0, 1'b0);
    t_reset();
    t_frame(MIN_PRE, 1'b0, 1'b1);   // accept, boundary preamble
    t_frame(MIN_PRE + 4, 1'b1, 1'b1);
    t_frame(MIN_PRE, 1'b0, 1'b0);
    t_frame(MIN_PRE + 2, 1'b1, 1'b0);
    t_short_preamble();
    t_disabled_data();
    t_gap_in_preamble();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule